// File: doc/BRIEF.md
# Coprocessor Count/Compare Timer

This block keeps the cycle counter and compare register of a processor's system-control coprocessor. A 32-bit count advances by one on every cycle in which `tick_en` is high, and wraps past all-ones to zero. When the count advances onto the value held in the compare register, the block raises a timer interrupt. That interrupt stays asserted until software writes the compare register again.

A hold bit in the cause register freezes the count. While the hold bit is set, the count cannot reach the compare value by advancing, so it cannot raise the interrupt. An architecture-revision input decides two things: whether the hold bit is writable, and whether a match also sets a pending flag in the cause register. The timer interrupt is placed on one of the eight lines of `irq_vec`. The line is chosen by a 3-bit field in the top bits of the interrupt-control register. That field is loaded from a parameter at reset and software cannot change it.

Software writes a register by raising `wr_en` for one cycle with a select code and data. Software reads a register by driving `rd_sel` and sampling `rd_data`, which is combinational. The select codes are 0 for count, 1 for compare, 2 for cause and 3 for interrupt control.

Top module: `cp0_count_timer`

## Requirements
- R1: When the cause hold bit is clear and `tick_en` is high at a rising edge, count becomes count+1 modulo 2^32. When `tick_en` is low, count keeps its value.
- R2: While cause bit 27 (hold) is set, count does not advance and reads return the held value. After hold is cleared, the next tick gives held value + 1.
- R3: A timer interrupt is raised only at the edge at which count advances onto the compare value. It is not raised while hold is set. It is not raised again by a count that stays equal after compare is rewritten.
- R4: A write to compare (select 1) loads the new value. At the same edge it clears cause bit 30 and drops the timer interrupt.
- R5: On a match the timer interrupt is asserted. Cause bit 30 is set only when `arch_rev` equals 1.
- R6: The timer interrupt appears only on `irq_vec[n]`, where n is interrupt-control bits 31:29. That field resets to parameter `TIMER_LINE` and reads back at that value.
- R7: A write to interrupt control (select 3) changes only the bits under mask 0x000002E0. All other bits keep their value.
- R8: A write to cause (select 2) changes only the bits under mask 0x00C00300. Bit 27 is also written, but only when `arch_rev` equals 1. Bit 30 is never written by software.
- R9: A write to count (select 0) loads the value at the next edge, even while hold is set. It takes priority over a tick in the same cycle.
- R10: After reset, count, compare and cause read 0, interrupt control reads `TIMER_LINE` in bits 31:29 with all other bits 0, and `irq_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count advance enable |
| arch_rev | input | 3 | Architecture revision; value 1 enables release-2 behaviour |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 count, 1 compare, 2 cause, 3 interrupt control |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select, same codes as wr_sel |
| rd_data | output | 32 | Read data, combinational from rd_sel |
| irq_vec | output | 8 | Interrupt lines; the timer drives one of them |

## Verification
The bench checks frozen counting by ticking a frozen count that sits one below compare. A design that froze only the read path would step onto compare and fire. It rewrites compare with the value the count already holds, to catch a level-sensitive match that retriggers straight away. It writes all-ones to cause and to interrupt control, to expose a bit that leaks through the write masks, such as the pending flag or the line field. With the revision input set to 0, it checks that the hold bit cannot be set and that a match still raises the line but leaves the pending flag clear. A second instance with a different line parameter confirms that the interrupt follows the field rather than a fixed line.

// File: rtl/cp0t_pkg.sv
package cp0t_pkg;

    localparam int unsigned WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        SEL_COUNT   = 2'd0,
        SEL_COMPARE = 2'd1,
        SEL_CAUSE   = 2'd2,
        SEL_INTCTL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     en;
        reg_sel_e sel;
        word_t    data;
    } reg_wr_t;

    // bits software may write, apart from the revision-gated hold bit
    localparam word_t CAUSE_SW_MASK  = 32'h00C0_0300;
    localparam word_t INTCTL_SW_MASK = 32'h0000_02E0;

    localparam int unsigned HOLD_BIT = 27;
    localparam int unsigned PEND_BIT = 30;

    localparam logic [2:0] REV2_CODE = 3'd1;

    function automatic word_t masked_merge(word_t old_v, word_t new_v, word_t mask);
        return (old_v & ~mask) | (new_v & mask);
    endfunction

    function automatic logic is_write(reg_wr_t w, reg_sel_e s);
        return w.en && (w.sel == s);
    endfunction

endpackage

// File: rtl/cp0t_counter.sv
module cp0t_counter
    import cp0t_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick_en,
    input  logic    hold,
    input  reg_wr_t wr,
    output word_t   count_o,
    output word_t   compare_o,
    output logic    match_o
);

    word_t count_q;
    word_t compare_q;
    word_t count_inc;
    logic  ld_cnt;
    logic  ld_cmp;
    logic  advance;

    assign ld_cnt    = is_write(wr, SEL_COUNT);
    assign ld_cmp    = is_write(wr, SEL_COMPARE);
    assign advance   = tick_en && !hold && !ld_cnt;
    assign count_inc = count_q + word_t'(1);
    // only a step onto compare counts as a match; a compare write wins
    assign match_o   = advance && !ld_cmp && (count_inc == compare_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            compare_q <= '0;
        end else begin
            if (ld_cnt) begin
                count_q <= wr.data;
            end else if (advance) begin
                count_q <= count_inc;
            end
            if (ld_cmp) begin
                compare_q <= wr.data;
            end
        end
    end

    assign count_o   = count_q;
    assign compare_o = compare_q;

    // R2: a frozen count without a software load keeps its value
    assert_hold_freezes_R2: assert property (@(posedge clk) disable iff (rst)
        (hold && !ld_cnt) |=> (count_q == $past(count_q)));

    // R9: a software load lands on the next edge regardless of hold
    assert_load_wins_R9: assert property (@(posedge clk) disable iff (rst)
        ld_cnt |=> (count_q == $past(wr.data)));

endmodule

// File: rtl/cp0t_ctrl_regs.sv
module cp0t_ctrl_regs
    import cp0t_pkg::*;
#(
    parameter int unsigned LINE_SEL_W = 3,
    parameter int unsigned TIMER_LINE = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rev2,
    input  reg_wr_t               wr,
    input  logic                  match,
    output word_t                 cause_o,
    output word_t                 intctl_o,
    output logic                  hold_o,
    output logic [LINE_SEL_W-1:0] line_o,
    output logic                  timer_o
);

    localparam int unsigned LINE_LSB     = WORD_W - LINE_SEL_W;
    localparam word_t       INTCTL_RESET = word_t'(TIMER_LINE) << LINE_LSB;

    word_t cause_q, cause_n;
    word_t intctl_q, intctl_n;
    word_t cause_mask;
    logic  timer_q, timer_n;
    logic  ld_cmp;
    logic  ld_cause;
    logic  ld_intctl;

    assign ld_cmp     = is_write(wr, SEL_COMPARE);
    assign ld_cause   = is_write(wr, SEL_CAUSE);
    assign ld_intctl  = is_write(wr, SEL_INTCTL);
    assign cause_mask = CAUSE_SW_MASK | (rev2 ? (word_t'(1) << HOLD_BIT) : '0);

    always_comb begin
        cause_n = cause_q;
        if (ld_cause) begin
            cause_n = masked_merge(cause_q, wr.data, cause_mask);
        end
        if (ld_cmp) begin
            cause_n[PEND_BIT] = 1'b0;
        end else if (match && rev2) begin
            cause_n[PEND_BIT] = 1'b1;
        end
    end

    always_comb begin
        intctl_n = intctl_q;
        if (ld_intctl) begin
            intctl_n = masked_merge(intctl_q, wr.data, INTCTL_SW_MASK);
        end
    end

    always_comb begin
        timer_n = timer_q;
        if (ld_cmp) begin
            timer_n = 1'b0;
        end else if (match) begin
            timer_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q  <= '0;
            intctl_q <= INTCTL_RESET;
            timer_q  <= 1'b0;
        end else begin
            cause_q  <= cause_n;
            intctl_q <= intctl_n;
            timer_q  <= timer_n;
        end
    end

    assign cause_o  = cause_q;
    assign intctl_o = intctl_q;
    assign hold_o   = cause_q[HOLD_BIT];
    assign line_o   = intctl_q[WORD_W-1 -: LINE_SEL_W];
    assign timer_o  = timer_q;

    // R4: compare write drops both the flag and the request
    assert_cmp_clears_R4: assert property (@(posedge clk) disable iff (rst)
        ld_cmp |=> (!timer_q && !cause_q[PEND_BIT]));

    // R7: interrupt-control bits outside the mask survive a write
    assert_intctl_mask_R7: assert property (@(posedge clk) disable iff (rst)
        ld_intctl |=> ((intctl_q & ~INTCTL_SW_MASK) == $past(intctl_q & ~INTCTL_SW_MASK)));

    // R8: without release 2 the hold bit cannot change
    assert_hold_gated_R8: assert property (@(posedge clk) disable iff (rst)
        !rev2 |=> (cause_q[HOLD_BIT] == $past(cause_q[HOLD_BIT])));

    // R5: pending flag never rises outside release 2
    assert_pend_rev_R5: assert property (@(posedge clk) disable iff (rst)
        !rev2 |=> !$rose(cause_q[PEND_BIT]));

endmodule

// File: rtl/cp0t_irq_route.sv
module cp0t_irq_route #(
    parameter int unsigned LINES = 8,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             timer,
    input  logic [SEL_W-1:0] sel,
    output logic [LINES-1:0] vec
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign vec[g] = timer && (sel == SEL_W'(g));
    end

    // R6: at most one line carries the timer
    assert_single_line_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(vec));

    // R6: the pending timer shows up on the selected line
    assert_selected_line_R6: assert property (@(posedge clk) disable iff (rst)
        timer |-> vec[sel]);

endmodule

// File: rtl/cp0_count_timer.sv
module cp0_count_timer
    import cp0t_pkg::*;
#(
    parameter int unsigned IRQ_LINES  = 8,
    parameter int unsigned TIMER_LINE = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_en,
    input  logic [2:0]           arch_rev,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic [1:0]           rd_sel,
    output logic [WORD_W-1:0]    rd_data,
    output logic [IRQ_LINES-1:0] irq_vec
);

    localparam int unsigned LINE_SEL_W = $clog2(IRQ_LINES);

    reg_wr_t               wr;
    word_t                 count_w;
    word_t                 compare_w;
    word_t                 cause_w;
    word_t                 intctl_w;
    logic                  match_w;
    logic                  hold_w;
    logic                  timer_w;
    logic                  rev2_w;
    logic [LINE_SEL_W-1:0] line_w;

    assign wr.en   = wr_en;
    assign wr.sel  = reg_sel_e'(wr_sel);
    assign wr.data = wr_data;
    assign rev2_w  = (arch_rev == REV2_CODE);

    cp0t_counter u_counter (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .hold      (hold_w),
        .wr        (wr),
        .count_o   (count_w),
        .compare_o (compare_w),
        .match_o   (match_w)
    );

    cp0t_ctrl_regs #(
        .LINE_SEL_W (LINE_SEL_W),
        .TIMER_LINE (TIMER_LINE)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .rev2     (rev2_w),
        .wr       (wr),
        .match    (match_w),
        .cause_o  (cause_w),
        .intctl_o (intctl_w),
        .hold_o   (hold_w),
        .line_o   (line_w),
        .timer_o  (timer_w)
    );

    cp0t_irq_route #(
        .LINES (IRQ_LINES),
        .SEL_W (LINE_SEL_W)
    ) u_route (
        .clk   (clk),
        .rst   (rst),
        .timer (timer_w),
        .sel   (line_w),
        .vec   (irq_vec)
    );

    always_comb begin
        unique case (reg_sel_e'(rd_sel))
            SEL_COUNT:   rd_data = count_w;
            SEL_COMPARE: rd_data = compare_w;
            SEL_CAUSE:   rd_data = cause_w;
            default:     rd_data = intctl_w;
        endcase
    end

    // R3: a frozen counter never makes the timer rise
    assert_frozen_no_irq_R3: assert property (@(posedge clk) disable iff (rst)
        hold_w |=> !$rose(timer_w));

    // R3: the timer rises only with the count landing on compare
    assert_rise_on_match_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(timer_w) |-> (count_w == compare_w));

endmodule

// File: tb/cp0_count_timer_tb.sv
module cp0_count_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 23;

    typedef struct packed {
        logic        wen;
        logic [1:0]  wsel;
        logic [31:0] wdat;
        logic        tick;
        logic [1:0]  rsel;
        logic [31:0] exp_rd;
        logic [7:0]  exp_irq;
        logic [3:0]  req;
    } vec_t;

    // one operation per entry, then a read of rsel after the edge
    localparam vec_t VECS [0:NVEC-1] = '{
        '{1'b1, 2'd0, 32'h0000_0010, 1'b1, 2'd0, 32'h0000_0010, 8'h00, 4'd9},  // R9 load beats tick
        '{1'b1, 2'd1, 32'h0000_0013, 1'b0, 2'd1, 32'h0000_0013, 8'h00, 4'd4},  // R4 compare load
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 32'h0000_0011, 8'h00, 4'd1},  // R1 tick
        '{1'b0, 2'd0, 32'h0,         1'b0, 2'd0, 32'h0000_0011, 8'h00, 4'd1},  // R1 no tick
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 32'h0000_0012, 8'h00, 4'd1},  // R1 tick
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 32'h0000_0013, 8'h80, 4'd5},  // R5 match
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd2, 32'h4000_0000, 8'h80, 4'd5},  // R5 pending set
        '{1'b1, 2'd1, 32'h0000_0020, 1'b1, 2'd2, 32'h0000_0000, 8'h00, 4'd4},  // R4 clear
        '{1'b1, 2'd2, 32'h08C0_0300, 1'b1, 2'd2, 32'h08C0_0300, 8'h00, 4'd8},  // R8 hold on
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 32'h0000_0016, 8'h00, 4'd2},  // R2 frozen
        '{1'b1, 2'd0, 32'h0000_001F, 1'b1, 2'd0, 32'h0000_001F, 8'h00, 4'd9},  // R9 load while frozen
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 32'h0000_001F, 8'h00, 4'd3},  // R3 no match frozen
        '{1'b1, 2'd2, 32'h0000_0000, 1'b0, 2'd2, 32'h0000_0000, 8'h00, 4'd8},  // R8 hold off
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 32'h0000_0020, 8'h80, 4'd2},  // R2 resume
        '{1'b0, 2'd0, 32'h0,         1'b0, 2'd2, 32'h4000_0000, 8'h80, 4'd5},  // R5 flag held
        '{1'b1, 2'd1, 32'h0000_0020, 1'b0, 2'd2, 32'h0000_0000, 8'h00, 4'd4},  // R4 same value
        '{1'b0, 2'd0, 32'h0,         1'b0, 2'd0, 32'h0000_0020, 8'h00, 4'd3},  // R3 no retrigger
        '{1'b1, 2'd3, 32'hFFFF_FFFF, 1'b0, 2'd3, 32'hE000_02E0, 8'h00, 4'd7},  // R7 all ones
        '{1'b1, 2'd3, 32'h0000_0000, 1'b0, 2'd3, 32'hE000_0000, 8'h00, 4'd7},  // R7 zeros
        '{1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0, 2'd2, 32'h08C0_0300, 8'h00, 4'd8},  // R8 all ones
        '{1'b1, 2'd2, 32'h0000_0000, 1'b0, 2'd2, 32'h0000_0000, 8'h00, 4'd8},  // R8 clear
        '{1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0, 2'd0, 32'hFFFF_FFFF, 8'h00, 4'd9},  // R9 load top
        '{1'b0, 2'd0, 32'h0,         1'b1, 2'd0, 32'h0000_0000, 8'h00, 4'd1}   // R1 wrap
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [2:0]  arch_rev = 3'd1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data, rd_alt;
    logic [7:0]  irq_vec, irq_alt;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cp0_count_timer u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .arch_rev(arch_rev),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq_vec(irq_vec)
    );

    cp0_count_timer #(.TIMER_LINE(2)) u_dut_alt (
        .clk(clk), .rst(rst), .tick_en(tick_en), .arch_rev(arch_rev),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_alt), .irq_vec(irq_alt)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic op(input logic wen, input logic [1:0] wsel, input logic [31:0] wdat,
                      input logic tick, input logic [1:0] rsel);
        @(negedge clk);
        wr_en = wen; wr_sel = wsel; wr_data = wdat; tick_en = tick;
        @(posedge clk);
        #1;
        wr_en = 1'b0; tick_en = 1'b0; rd_sel = rsel;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10 reset values
        rd_sel = 2'd0; #1; check("R10 count", rd_data, 32'h0);
        rd_sel = 2'd1; #1; check("R10 compare", rd_data, 32'h0);
        rd_sel = 2'd2; #1; check("R10 cause", rd_data, 32'h0);
        rd_sel = 2'd3; #1; check("R10 intctl", rd_data, 32'hE000_0000);
        check("R6 alt intctl field", rd_alt, 32'h4000_0000);
        check("R10 irq", {24'h0, irq_vec}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            op(VECS[i].wen, VECS[i].wsel, VECS[i].wdat, VECS[i].tick, VECS[i].rsel);
            check($sformatf("R%0d vec%0d read", VECS[i].req, i), rd_data, VECS[i].exp_rd);
            check($sformatf("R%0d vec%0d irq", VECS[i].req, i), {24'h0, irq_vec}, {24'h0, VECS[i].exp_irq});
            check($sformatf("R6 vec%0d alt irq", i), {24'h0, irq_alt},
                  (VECS[i].exp_irq != 8'h00) ? 32'h04 : 32'h00);
        end

        // release-1 behaviour: count 0, compare 0x20, cause 0 here
        arch_rev = 3'd0;
        op(1'b1, 2'd2, 32'h0800_0000, 1'b0, 2'd2);
        check("R8 hold not writable rev0", rd_data, 32'h0);
        op(1'b1, 2'd0, 32'h0000_001F, 1'b0, 2'd0);
        op(1'b0, 2'd0, 32'h0, 1'b1, 2'd2);
        check("R5 no pending rev0", rd_data, 32'h0);
        check("R5 irq rev0", {24'h0, irq_vec}, 32'h80);
        check("R6 alt line rev0", {24'h0, irq_alt}, 32'h04);
        op(1'b1, 2'd1, 32'h0000_0005, 1'b0, 2'd2);
        check("R4 clear rev0 irq", {24'h0, irq_vec}, 32'h0);
        op(1'b0, 2'd0, 32'h0, 1'b1, 2'd0);
        check("R8 counting after ignored hold", rd_data, 32'h21);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule